// File: doc/BRIEF.md
# Converter Power-Mode Guard Sequencer

This block sits on the host side of a sampling converter and owns the converter's two power-down lines: a light sleep line (nap) and a deep sleep line (standby). It takes single-cycle requests for nap, standby, wake and sampling. It turns sampling requests into single-cycle convert-start pulses. It also makes sure that no convert-start pulse leaves the block before the converter has settled after a power-down.

The settle window depends on how deep the converter slept and on which reference it uses. After a nap it is a short window, and nap is only legal with an external reference. After standby with the internal reference it is a long window. After standby with an external reference that stayed powered it is a medium window. All three windows are parameters counted in system clock cycles, so a bench can scale them down. The host also reports which reference is active. A sampling request that arrives while the converter sleeps, settles or converts is held, and it is served as soon as the rules allow.

An optional auto-nap mode duty-cycles the converter. When a conversion ends (the active-low busy line returns high), the block naps at once. The next sampling request wakes the converter, waits out the nap window and then starts the conversion.

Top module: `pwr_guard_seq`

## Requirements
- R1: After reset, nap_o, stby_o, convst_o and nap_err_o are 0, and ready_o is 1.
- R2: In the run state with no conversion in flight, nap_req_i with int_ref_i=0 raises nap_o on the next cycle, and stby_req_i raises stby_o on the next cycle. If both requests arrive together, standby wins. A stby_req_i while napped moves the converter to standby (nap_o low and stby_o high together). nap_o and stby_o are never high together.
- R3: nap_req_i while int_ref_i=1 is refused: nap_o stays 0 and nap_err_o rises on the next cycle. nap_err_o then stays 1 until reset.
- R4: wake_req_i while napped lowers nap_o on the next cycle. The first convert-start pulse after that comes no earlier than NAP_SETTLE_CYC+1 cycles after nap_o fell, and exactly then if a sample request is already held.
- R5: wake_req_i in standby lowers stby_o on the next cycle. The settle window is then STBY_INT_CYC if int_ref_i=1 in the wake cycle, and STBY_EXT_CYC otherwise. With a held request, convst_o rises exactly window+1 cycles after stby_o fell.
- R6: A sample request that cannot be served is held, not dropped. Several requests made while one is already held merge into a single conversion.
- R7: convst_o is a one-cycle pulse. It rises one cycle after a served sample request is registered. It is issued only in the run state, with the guard window over and no conversion in flight. A conversion is in flight from the pulse until busy_n_i returns high after having gone low.
- R8: With auto_nap_i=1 and int_ref_i=0, nap_o rises one cycle after busy_n_i is first seen high again at the end of a conversion, unless a sample request is held. In that case the block does not nap, and convst_o follows one cycle later. A sample request while auto-napped wakes the converter, and conversion follows after the nap window as in R4.
- R9: With auto_nap_i=1 and int_ref_i=1, the end of a conversion does not nap the converter and does not set nap_err_o.
- R10: Nap and standby requests made while a conversion is in flight are ignored. wake_req_i in the run state is ignored and does not restart the guard window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nap_req_i | input | 1 | Request to enter nap (one-cycle pulse) |
| stby_req_i | input | 1 | Request to enter standby (one-cycle pulse) |
| wake_req_i | input | 1 | Request to leave nap or standby (one-cycle pulse) |
| sample_req_i | input | 1 | Request for one conversion (one-cycle pulse) |
| int_ref_i | input | 1 | 1 = internal reference in use, 0 = external reference |
| auto_nap_i | input | 1 | 1 = nap after every conversion |
| busy_n_i | input | 1 | Converter busy line, low while converting |
| nap_o | output | 1 | Drives the converter nap line |
| stby_o | output | 1 | Drives the converter standby line |
| convst_o | output | 1 | Convert-start pulse, one cycle |
| nap_err_o | output | 1 | Sticky flag: nap refused with the internal reference |
| ready_o | output | 1 | Awake, guard window over, no conversion in flight |

## Verification
The guard counter and the held-request flag are internal, so an error in them shows up mainly in when convst_o appears. If the counter is loaded with the wrong window or decrements wrongly, the first pulse after a wake moves by one or more cycles. Measuring the exact cycle distance from the falling sleep line to the pulse exposes this on the first wake from each mode. A lost held request shows up as a missing pulse within a few cycles of the window ending. A request served twice shows up as an extra pulse once busy_n_i returns. An auto-nap decision taken in the wrong cycle is visible one cycle after busy_n_i rises.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_NAP  = 2'd1,
    PM_STBY = 2'd2
  } pm_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  p_timer_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
#(
  parameter int unsigned TW             = 8,
  parameter int unsigned NAP_SETTLE_CYC = 6,
  parameter int unsigned STBY_INT_CYC   = 40,
  parameter int unsigned STBY_EXT_CYC   = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nap_req_i,
  input  logic          stby_req_i,
  input  logic          wake_req_i,
  input  logic          int_ref_i,
  input  logic          auto_nap_i,
  input  logic          conv_active_i,
  input  logic          conv_done_i,
  input  logic          pend_i,
  output logic          run_o,
  output logic          leave_o,
  output logic          nap_o,
  output logic          stby_o,
  output logic          nap_err_o,
  output logic          load_o,
  output logic [TW-1:0] load_val_o
);

  pm_state_e st_q, st_d;
  logic      err_q, err_set;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    err_set    = 1'b0;
    unique case (st_q)
      PM_RUN: begin
        if (conv_active_i) begin
          // end of conversion: duty-cycle nap unless more work waits
          if (conv_done_i && auto_nap_i && !int_ref_i && !pend_i) st_d = PM_NAP;
        end else if (stby_req_i) begin
          st_d = PM_STBY;
        end else if (nap_req_i) begin
          if (int_ref_i) err_set = 1'b1;
          else           st_d    = PM_NAP;
        end
      end
      PM_NAP: begin
        if (stby_req_i) begin
          st_d = PM_STBY;
        end else if (wake_req_i || (auto_nap_i && pend_i)) begin
          st_d       = PM_RUN;
          load_o     = 1'b1;
          load_val_o = TW'(NAP_SETTLE_CYC);
        end
      end
      PM_STBY: begin
        if (wake_req_i) begin
          st_d       = PM_RUN;
          load_o     = 1'b1;
          load_val_o = int_ref_i ? TW'(STBY_INT_CYC) : TW'(STBY_EXT_CYC);
        end
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PM_RUN;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      if (err_set) err_q <= 1'b1;
    end
  end

  assign run_o     = (st_q == PM_RUN);
  assign leave_o   = (st_q == PM_RUN) && (st_d != PM_RUN);
  assign nap_o     = (st_q == PM_NAP);
  assign stby_o    = (st_q == PM_STBY);
  assign nap_err_o = err_q;

  p_sleep_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nap_o && stby_o));

  p_nap_int_ref_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nap_o) |-> !$past(int_ref_i));

  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nap_err_o |=> nap_err_o);

endmodule

// File: rtl/pwr_guard_gate.sv
module pwr_guard_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_req_i,
  input  logic busy_n_i,
  input  logic run_i,
  input  logic guard_done_i,
  input  logic leave_i,
  output logic convst_o,
  output logic conv_active_o,
  output logic conv_done_o,
  output logic pend_o
);

  logic pend_q, conv_q, busy_q, start_q, issue;

  assign conv_done_o = conv_q && busy_n_i && !busy_q;
  assign issue       = pend_q && run_i && guard_done_i && !conv_q && !leave_i;
  assign pend_o      = pend_q || sample_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      conv_q  <= 1'b0;
      busy_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      busy_q  <= busy_n_i;
      start_q <= issue;
      pend_q  <= (pend_q && !issue) || sample_req_i;
      if (issue)            conv_q <= 1'b1;
      else if (conv_done_o) conv_q <= 1'b0;
    end
  end

  assign convst_o      = start_q;
  assign conv_active_o = conv_q;

  p_convst_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_o |=> !convst_o);

  p_convst_marks_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_o |-> conv_active_o);

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 100_000_000,
  parameter int unsigned NAP_SETTLE_CYC = (CLK_HZ / 1_000_000) * 3 / 10,
  parameter int unsigned STBY_INT_CYC   = CLK_HZ / 2,
  parameter int unsigned STBY_EXT_CYC   = CLK_HZ / 12_500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nap_req_i,
  input  logic stby_req_i,
  input  logic wake_req_i,
  input  logic sample_req_i,
  input  logic int_ref_i,
  input  logic auto_nap_i,
  input  logic busy_n_i,
  output logic nap_o,
  output logic stby_o,
  output logic convst_o,
  output logic nap_err_o,
  output logic ready_o
);

  localparam int unsigned MAX_CYC = max3(NAP_SETTLE_CYC, STBY_INT_CYC, STBY_EXT_CYC);
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);

  logic          run, leave, load, guard_done;
  logic          conv_active, conv_done, pend;
  logic [TW-1:0] load_val;

  pwr_guard_fsm #(
    .TW             (TW),
    .NAP_SETTLE_CYC (NAP_SETTLE_CYC),
    .STBY_INT_CYC   (STBY_INT_CYC),
    .STBY_EXT_CYC   (STBY_EXT_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .nap_req_i     (nap_req_i),
    .stby_req_i    (stby_req_i),
    .wake_req_i    (wake_req_i),
    .int_ref_i     (int_ref_i),
    .auto_nap_i    (auto_nap_i),
    .conv_active_i (conv_active),
    .conv_done_i   (conv_done),
    .pend_i        (pend),
    .run_o         (run),
    .leave_o       (leave),
    .nap_o         (nap_o),
    .stby_o        (stby_o),
    .nap_err_o     (nap_err_o),
    .load_o        (load),
    .load_val_o    (load_val)
  );

  pwr_guard_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (guard_done)
  );

  pwr_guard_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sample_req_i  (sample_req_i),
    .busy_n_i      (busy_n_i),
    .run_i         (run),
    .guard_done_i  (guard_done),
    .leave_i       (leave),
    .convst_o      (convst_o),
    .conv_active_o (conv_active),
    .conv_done_o   (conv_done),
    .pend_o        (pend)
  );

  assign ready_o = run && guard_done && !conv_active;

  // independent settle-window tracker for the guard property
  logic [TW:0]   since_q;
  logic [TW-1:0] need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      need_q  <= '0;
    end else if (nap_o || stby_o) begin
      since_q <= '0;
      need_q  <= stby_o ? (int_ref_i ? TW'(STBY_INT_CYC) : TW'(STBY_EXT_CYC))
                        : TW'(NAP_SETTLE_CYC);
    end else if (since_q != '1) begin
      since_q <= since_q + (TW+1)'(1);
    end
  end

  p_settle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_o |-> (since_q > {1'b0, need_q}));

  p_convst_awake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_o |-> (!nap_o && !stby_o));

endmodule

// File: tb/pwr_guard_seq_tb.sv
module pwr_guard_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NAP_C  = 6;
  localparam int INT_C  = 40;
  localparam int EXT_C  = 15;
  localparam int CONV_C = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic nap_req_i = 1'b0, stby_req_i = 1'b0, wake_req_i = 1'b0, sample_req_i = 1'b0;
  logic int_ref_i = 1'b0, auto_nap_i = 1'b0;
  logic busy_n_i;
  logic nap_o, stby_o, convst_o, nap_err_o, ready_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwr_guard_seq #(
    .NAP_SETTLE_CYC (NAP_C),
    .STBY_INT_CYC   (INT_C),
    .STBY_EXT_CYC   (EXT_C)
  ) u_dut (
    .clk_i, .rst_ni, .nap_req_i, .stby_req_i, .wake_req_i, .sample_req_i,
    .int_ref_i, .auto_nap_i, .busy_n_i, .nap_o, .stby_o, .convst_o, .nap_err_o, .ready_o
  );

  // converter model: busy low for CONV_C cycles after a start pulse
  int conv_cnt;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       conv_cnt <= 0;
    else if (convst_o) conv_cnt <= CONV_C;
    else if (conv_cnt != 0) conv_cnt <= conv_cnt - 1;
  end
  assign busy_n_i = (conv_cnt == 0);

  // settle monitor, computed from R4/R5
  int since_m = 0;
  int need_m  = 0;
  always @(posedge clk_i) begin
    if (nap_o || stby_o) begin
      since_m <= 0;
      need_m  <= stby_o ? (int_ref_i ? INT_C : EXT_C) : NAP_C;
    end else if (since_m < 1000000) begin
      since_m <= since_m + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && convst_o) begin
      chk(since_m > need_m, "R4/R5 settle window before convst", since_m, need_m + 1);
      chk(!nap_o && !stby_o, "R7 convst while asleep", {nap_o, stby_o}, 0);
    end
    if (rst_ni && nap_o && stby_o) chk(1'b0, "R2 nap and standby together", 1, 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: sample_req_i = 1'b1;
      1: nap_req_i    = 1'b1;
      2: stby_req_i   = 1'b1;
      default: wake_req_i = 1'b1;
    endcase
    step(1);
    sample_req_i = 1'b0; nap_req_i = 1'b0; stby_req_i = 1'b0; wake_req_i = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim && !ready_o; i++) step(1);
  endtask

  task automatic wait_convst(input int lim, output int c);
    c = 0;
    for (int i = 0; i < lim; i++) begin
      step(1);
      c++;
      if (convst_o) break;
    end
    if (!convst_o) c = -1;
  endtask

  task automatic wait_busy(input logic lvl, input int lim);
    for (int i = 0; i < lim && busy_n_i != lvl; i++) step(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int c;
    int pulses;
    void'($urandom(32'd20240611));
    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state
    chk_eq("R1 nap_o", nap_o, 0);
    chk_eq("R1 stby_o", stby_o, 0);
    chk_eq("R1 convst_o", convst_o, 0);
    chk_eq("R1 nap_err_o", nap_err_o, 0);
    chk_eq("R1 ready_o", ready_o, 1);

    // R7 single conversion, one-cycle pulse
    pulse(0);
    chk_eq("R7 no convst in request cycle", convst_o, 0);
    step(1);
    chk_eq("R7 convst one cycle after request", convst_o, 1);
    step(1);
    chk_eq("R7 convst single cycle", convst_o, 0);
    wait_ready(50);

    // R10 wake in run ignored
    pulse(3);
    chk_eq("R10 wake in run keeps ready", ready_o, 1);

    // R10 sleep during conversion ignored
    pulse(0);
    step(1);
    pulse(1);
    chk_eq("R10 nap ignored in conversion", nap_o, 0);
    pulse(2);
    chk_eq("R10 standby ignored in conversion", stby_o, 0);
    wait_ready(50);

    // R9 auto-nap with internal reference
    int_ref_i = 1'b1; auto_nap_i = 1'b1;
    pulse(0);
    wait_busy(1'b0, 20);
    wait_busy(1'b1, 20);
    step(1);
    chk_eq("R9 no auto-nap with internal ref", nap_o, 0);
    step(1);
    chk_eq("R9 no error from auto-nap", nap_err_o, 0);
    wait_ready(50);

    // R8 auto-nap with external reference
    int_ref_i = 1'b0;
    pulse(0);
    step(1);
    chk_eq("R8 convst before auto-nap", convst_o, 1);
    wait_busy(1'b0, 20);
    wait_busy(1'b1, 20);
    step(1);
    chk_eq("R8 nap after busy returns", nap_o, 1);
    pulse(0);
    chk_eq("R8 sample wakes from auto-nap", nap_o, 0);
    wait_convst(100, c);
    chk_eq("R8 auto wake settle to convst", c, NAP_C + 1);

    // R8 held request skips nap
    wait_busy(1'b0, 20);
    pulse(0);
    wait_busy(1'b1, 20);
    step(1);
    chk_eq("R8 no nap with held request", nap_o, 0);
    step(1);
    chk_eq("R8 held request converts next", convst_o, 1);
    wait_busy(1'b0, 20);
    wait_busy(1'b1, 20);
    step(2);
    chk_eq("R8 nap after last conversion", nap_o, 1);
    auto_nap_i = 1'b0;
    pulse(3);
    wait_ready(50);

    // R2/R4/R6 manual nap with held request
    pulse(1);
    chk_eq("R2 nap_o on request", nap_o, 1);
    pulse(0);
    step(10);
    chk_eq("R6 request held while napped", convst_o, 0);
    chk_eq("R6 still napped", nap_o, 1);
    pulse(3);
    chk_eq("R4 nap_o falls on wake", nap_o, 0);
    wait_convst(100, c);
    chk_eq("R4 nap settle to convst", c, NAP_C + 1);
    wait_ready(50);

    // R2 priority
    nap_req_i = 1'b1; stby_req_i = 1'b1;
    step(1);
    nap_req_i = 1'b0; stby_req_i = 1'b0;
    chk_eq("R2 standby wins stby_o", stby_o, 1);
    chk_eq("R2 standby wins nap_o", nap_o, 0);
    pulse(3);
    wait_ready(100);

    // R2 nap to standby
    pulse(1);
    pulse(2);
    chk_eq("R2 nap to standby stby_o", stby_o, 1);
    chk_eq("R2 nap to standby nap_o", nap_o, 0);
    pulse(3);
    wait_ready(100);

    // R5 standby internal
    int_ref_i = 1'b1;
    pulse(2);
    pulse(0);
    pulse(3);
    chk_eq("R5 stby_o falls on wake", stby_o, 0);
    wait_convst(200, c);
    chk_eq("R5 internal ref window", c, INT_C + 1);
    wait_ready(50);

    // R5 standby external
    int_ref_i = 1'b0;
    pulse(2);
    pulse(0);
    pulse(3);
    wait_convst(200, c);
    chk_eq("R5 external ref window", c, EXT_C + 1);
    wait_ready(50);

    // R6 merged requests
    pulse(2);
    pulse(0); step(2); pulse(0); step(2); pulse(0);
    pulse(3);
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      step(1);
      if (convst_o) pulses++;
    end
    chk_eq("R6 merged requests one conversion", pulses, 1);

    // R3 nap refused with internal ref
    int_ref_i = 1'b1;
    pulse(1);
    chk_eq("R3 nap refused", nap_o, 0);
    chk_eq("R3 error set", nap_err_o, 1);
    step(5);
    chk_eq("R3 error sticky", nap_err_o, 1);

    // constrained random phase, checked by the monitor
    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom_range(0, 5);
      if (op < 4) pulse(op);
      else if (op == 4) int_ref_i = $urandom_range(0, 1);
      else auto_nap_i = $urandom_range(0, 1);
      step($urandom_range(1, 20));
    end

    // final drain: a request must be served after waking
    auto_nap_i = 1'b0;
    pulse(3);
    wait_ready(200);
    pulse(3);
    wait_ready(200);
    pulse(0);
    wait_convst(300, c);
    chk(c > 0, "R6 request served after random phase", c, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule